// File: doc/BRIEF.md
# Error Pulse Width Safety Monitor

This block sits beside a processor, outside it. It watches two things: the processor's active-low error pin and the periodic trigger line that the processor uses to service an external watchdog. Each time the error pin goes low, the block measures how long it stays low and then decides whether the event is a fault.

A short low pulse means the processor is running a diagnostic self-test of its error signalling. The block does not react to it, except that it sets a sticky flag that confirms the pulse reached the board. A long low pulse means a real, severe fault. In that case the block cuts the trigger path to the watchdog for good and asserts a request that keeps the processor in power-on reset.

Because of this split, the error pin never drives the power-on reset directly, so self-tests can run. Only a power-on reset of the monitor itself clears a fault that has been latched. A processor that keeps toggling its trigger output can therefore not revive the watchdog, and the design cannot enter a reset loop.

Top module: `err_pulse_monitor`

## Requirements
- R1: After `rst_n` is released, `fault_latched`, `por_hold` and `selftest_seen` are all 0.
- R2: While no fault is latched and the error pin is high, `wdt_trig_out` equals `wdt_trig_in` in the same cycle, with no register between them.
- R3: The width W of an error-pin low pulse is the number of rising clock edges that sample it low. A pulse with 1 <= W < TEST_MAX sets `selftest_seen` and does not latch a fault.
- R4: Once `selftest_seen` is set, it stays 1 until `rst_n` is asserted, whatever pulses follow.
- R5: A pulse with W >= FAULT_MIN latches the fault while the pin is still low. The latch happens no later than FAULT_MIN + 3 clock edges after the pin falls.
- R6: A pulse with TEST_MAX <= W < FAULT_MIN latches the fault when the pulse ends, and does not set `selftest_seen`.
- R7: While a fault is latched, `wdt_trig_out` is 0 whatever `wdt_trig_in` or the error pin do.
- R8: While a fault is latched, `por_hold` is 1.
- R9: A latched fault stays latched until `rst_n` is asserted. No later activity on the error pin or the trigger line clears it.
- R10: While the synchronized error pin is low, `wdt_trig_out` is held at 0 even if no fault is latched yet.
- R11: The error pin passes through a two-flop synchronizer. Its effect on `wdt_trig_out` therefore appears on the second rising edge after the pin changes, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the monitor |
| err_pin_n | input | 1 | Processor error pin, active low, asynchronous |
| wdt_trig_in | input | 1 | Watchdog trigger from the processor |
| wdt_trig_out | output | 1 | Gated watchdog trigger toward the watchdog |
| por_hold | output | 1 | Request to hold the processor in power-on reset |
| fault_latched | output | 1 | Fault state has been latched |
| selftest_seen | output | 1 | Sticky flag: a self-test pulse was observed |

## Verification
A width counter that is off by one shows up at the ports as the wrong classification of a pulse whose width is exactly TEST_MAX or exactly FAULT_MIN. It becomes visible one edge after the pulse ends, or at the edge where the pulse reaches FAULT_MIN cycles. A latch that clears itself by mistake shows up at once as `wdt_trig_out` following `wdt_trig_in` again while `por_hold` drops. A missing or extra synchronizer stage shifts the edge at which the trigger gating starts during a pulse by one cycle.

// File: rtl/epm_pkg.sv
package epm_pkg;
  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_TEST  = 2'd1,
    CLS_FAULT = 2'd2
  } pulse_cls_e;
endpackage

// File: rtl/epm_reset_sync.sv
module epm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_out_n = chain_q[STAGES-1];
endmodule

// File: rtl/epm_bit_sync.sv
module epm_bit_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb stage_d = {stage_q[STAGES-2:0], d_async};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RESET_VAL}};
    else        stage_q <= stage_d;
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/epm_width_classifier.sv
module epm_width_classifier
  import epm_pkg::*;
#(
  parameter int TEST_MAX  = 8,
  parameter int FAULT_MIN = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_low,
  output pulse_cls_e evt
);
  localparam int CNT_W = $clog2(FAULT_MIN + 1);
  localparam logic [CNT_W-1:0] SAT_VAL   = CNT_W'(FAULT_MIN);
  localparam logic [CNT_W-1:0] FAULT_HIT = CNT_W'(FAULT_MIN - 1);
  localparam logic [CNT_W-1:0] TEST_LIM  = CNT_W'(TEST_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // cnt_q holds the number of low cycles sampled before the current one
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    evt    = CLS_NONE;
    if (err_low) begin
      if (cnt_q != SAT_VAL) begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
      if (cnt_q == FAULT_HIT) evt = CLS_FAULT;
    end else if (cnt_q != '0) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
      evt    = (cnt_q < TEST_LIM) ? CLS_TEST : CLS_FAULT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/epm_safe_latch.sv
module epm_safe_latch
  import epm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pulse_cls_e evt,
  input  logic       err_low,
  input  logic       trig_in,
  output logic       trig_out,
  output logic       fault_q,
  output logic       seen_q
);
  logic fault_d, fault_en;
  logic seen_d, seen_en;

  always_comb begin
    fault_en = (evt == CLS_FAULT) && !fault_q;
    fault_d  = 1'b1;
    seen_en  = (evt == CLS_TEST) && !seen_q;
    seen_d   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fault_q <= 1'b0;
    else if (fault_en) fault_q <= fault_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= 1'b0;
    else if (seen_en) seen_q <= seen_d;
  end

  always_comb trig_out = trig_in & ~fault_q & ~err_low;
endmodule

// File: rtl/err_pulse_monitor.sv
module err_pulse_monitor
  import epm_pkg::*;
#(
  parameter int TEST_MAX    = 8,
  parameter int FAULT_MIN   = 32,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_pin_n,
  input  logic wdt_trig_in,
  output logic wdt_trig_out,
  output logic por_hold,
  output logic fault_latched,
  output logic selftest_seen
);
  logic       rst_int_n;
  logic       err_pin_s;
  logic       err_low_s;
  pulse_cls_e cls_evt;
  logic       fault_q;
  logic       seen_q;

  epm_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_in_n(rst_n), .rst_out_n(rst_int_n)
  );

  epm_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_async(err_pin_n), .q_sync(err_pin_s)
  );

  assign err_low_s = ~err_pin_s;

  epm_width_classifier #(.TEST_MAX(TEST_MAX), .FAULT_MIN(FAULT_MIN)) u_cls (
    .clk(clk), .rst_n(rst_int_n), .err_low(err_low_s), .evt(cls_evt)
  );

  epm_safe_latch u_latch (
    .clk(clk), .rst_n(rst_int_n), .evt(cls_evt), .err_low(err_low_s),
    .trig_in(wdt_trig_in), .trig_out(wdt_trig_out),
    .fault_q(fault_q), .seen_q(seen_q)
  );

  assign por_hold      = fault_q;
  assign fault_latched = fault_q;
  assign selftest_seen = seen_q;
endmodule

// File: rtl/err_pulse_monitor_chk.sv
module err_pulse_monitor_chk #(
  parameter int FAULT_MIN = 32
) (
  input logic clk,
  input logic rst_n,
  input logic err_low,
  input logic wdt_trig_out,
  input logic por_hold,
  input logic fault_latched,
  input logic selftest_seen
);
  localparam int RW = $clog2(FAULT_MIN + 1);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           run_q <= '0;
    else if (!err_low)                    run_q <= '0;
    else if (run_q != RW'(FAULT_MIN))     run_q <= run_q + 1'b1;
  end

  assert_fault_on_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == RW'(FAULT_MIN)) |-> fault_latched);

  assert_trig_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> !wdt_trig_out);

  assert_por_with_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> por_hold);

  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |=> fault_latched);

  assert_seen_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    selftest_seen |=> selftest_seen);

  assert_seen_after_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selftest_seen) |-> !$past(err_low) || !err_low);

  assert_trig_low_during_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_low |-> !wdt_trig_out);
endmodule

bind err_pulse_monitor err_pulse_monitor_chk #(.FAULT_MIN(FAULT_MIN)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .err_low(err_low_s),
  .wdt_trig_out(wdt_trig_out), .por_hold(por_hold),
  .fault_latched(fault_latched), .selftest_seen(selftest_seen)
);

// File: tb/test_err_pulse_monitor.sv
module test_err_pulse_monitor;
  localparam int TEST_MAX  = 8;
  localparam int FAULT_MIN = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic err_pin_n;
  logic wdt_trig_in;
  logic wdt_trig_out, por_hold, fault_latched, selftest_seen;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  err_pulse_monitor #(.TEST_MAX(TEST_MAX), .FAULT_MIN(FAULT_MIN)) i_err_pulse_monitor (
    .clk(clk), .rst_n(rst_n), .err_pin_n(err_pin_n), .wdt_trig_in(wdt_trig_in),
    .wdt_trig_out(wdt_trig_out), .por_hold(por_hold),
    .fault_latched(fault_latched), .selftest_seen(selftest_seen)
  );

  function automatic bit exp_fault(int w);
    return (w >= TEST_MAX);
  endfunction

  function automatic bit exp_seen(int w);
    return (w >= 1) && (w < TEST_MAX);
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; err_pin_n = 1'b1; wdt_trig_in = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic pulse(int w);
    err_pin_n = 1'b0;
    step(w);
    err_pin_n = 1'b1;
    step(4);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; err_pin_n = 1'b1; wdt_trig_in = 1'b0;
    do_reset();
    #1;
    check("R1 fault", fault_latched, 1'b0);
    check("R1 por", por_hold, 1'b0);
    check("R1 seen", selftest_seen, 1'b0);

    // R2 random pass-through
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      wdt_trig_in = 1'($urandom);
      #1 check("R2 passthrough", wdt_trig_out, wdt_trig_in);
    end

    // R11 / R10: gating starts on second edge after pin falls
    @(negedge clk);
    wdt_trig_in = 1'b1; err_pin_n = 1'b0;
    @(negedge clk); #1 check("R11 one edge", wdt_trig_out, 1'b1);
    @(negedge clk); #1 check("R10 two edges", wdt_trig_out, 1'b0);
    step(1); err_pin_n = 1'b1;
    step(4);

    // R3 boundary W=TEST_MAX-1 and R4 sticky
    do_reset();
    pulse(TEST_MAX - 1); #1;
    check("R3 seen", selftest_seen, 1'b1);
    check("R3 no fault", fault_latched, 1'b0);
    check("R3 no por", por_hold, 1'b0);
    step(50); #1 check("R4 sticky idle", selftest_seen, 1'b1);

    // R6 boundary W=TEST_MAX and mid band
    do_reset();
    pulse(TEST_MAX); #1;
    check("R6 fault at TEST_MAX", fault_latched, 1'b1);
    check("R6 no seen", selftest_seen, 1'b0);
    do_reset();
    pulse(FAULT_MIN - 1); #1;
    check("R6 fault at FAULT_MIN-1", fault_latched, 1'b1);

    // R5 latch while still low, R7, R8, R9, R4
    do_reset();
    pulse(3);
    @(negedge clk);
    err_pin_n = 1'b0;
    step(FAULT_MIN + 2); #1;
    check("R5 latched before pin high", fault_latched, 1'b1);
    check("R8 por", por_hold, 1'b1);
    err_pin_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      wdt_trig_in = ~wdt_trig_in;
      #1 check("R7 blocked", wdt_trig_out, 1'b0);
    end
    pulse(2); pulse(40); #1;
    check("R9 still latched", fault_latched, 1'b1);
    check("R4 sticky after pulses", selftest_seen, 1'b1);
    do_reset(); #1;
    check("R9 cleared by reset", fault_latched, 1'b0);
    check("R1 seen cleared", selftest_seen, 1'b0);

    // random widths
    for (int t = 0; t < 40; t++) begin
      int w;
      w = 1 + int'($urandom_range(0, FAULT_MIN + 8));
      do_reset();
      pulse(w); #1;
      check(exp_fault(w) ? "R6 random fault" : "R3 random fault", fault_latched, exp_fault(w));
      check("R3 random seen", selftest_seen, exp_seen(w));
      @(negedge clk);
      wdt_trig_in = 1'b1;
      #1 check(exp_fault(w) ? "R7 random trig" : "R2 random trig", wdt_trig_out, !exp_fault(w));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule